// File: doc/BRIEF.md
# Banked Host Register Interface

This block is the microprocessor-facing side of a peripheral's register space. A host reaches it over a 16-bit data path with a chip select and a 5-bit word address, where word n sits at byte offset 2n (00h to 3Eh). Two strapping inputs fix how the bus behaves. The first picks the strobe style: either separate active-low read and write strobes, or a read/write level with an active-low data strobe. The second picks the address source: either dedicated address pins, or an address carried on data lines 5..1 and latched while the address-latch-enable input is high.

The address space has a common window and a banked window. The common window is 00h to 0Eh plus 3Eh, and it reaches the same registers whatever bank is selected. The banked window is 10h to 3Ch, and it reaches one of three banks picked by the bank-select register at 3Eh. Some addresses are split, so a write and a read at the same address reach different things. The block holds a small register set: a mode-control word, common scratch words, per-bank scratch words and the bank selector. The mode-control word is exported to the surrounding core.

The inputs are sampled on the block clock. A write is committed after its strobe is released. Read data appears on the cycle after the read strobe is seen, together with an output-enable that the pad ring uses to drive the bus.

Top module: `banked_host_regs`

## Requirements
- R1: After reset, the bank selector is 0, mode_ctl is 0000h, every scratch word reads 0000h, data_oe is 0 and data_out is 0000h.
- R2: A write of 0000h, 0001h or 0002h to 3Eh selects bank 0, 1 or 2. A write of any other value to 3Eh leaves the selection unchanged. A read of 3Eh returns the selected bank number in bits 1..0, with all other bits 0.
- R3: Words 04h and 06h are common scratch registers. They read back the same value whichever bank is selected.
- R4: Words 10h, 12h, 14h and 16h are scratch registers with a separate copy in each bank. A write or read at these words reaches only the copy in the selected bank.
- R5: Address 00h is split. A write there loads mode_ctl. A read there returns a status word with the selected bank in bits 1..0, the strobe-style strap in bit 8, the multiplex strap in bit 9, and 0 in all other bits.
- R6: Address 02h is split. A write there has no effect on any register, and a read there returns 0000h.
- R7: The reserved words 08h to 0Eh and 18h to 3Ch ignore writes and read 0000h. A write to them changes no other register.
- R8: With strap_style = 0, a read is cs_n = 0 with rd_n = 0, and a write is cs_n = 0 with wr_n = 0.
- R9: With strap_style = 1, rd_n acts as a read/write level (1 = read, 0 = write) and wr_n acts as the data strobe. With the data strobe high, nothing is read and nothing is written.
- R10: With strap_mux = 1, the word address is taken from data_in[5:1] while ale is high, and addr_pin is ignored.
- R11: data_oe is 1 only in the cycle after a read with chip select active. In every other cycle data_oe is 0 and data_out is 0000h. Read data appears on data_out one cycle after the read strobe is sampled.
- R12: A write takes effect one clock after the strobe is released. It uses the data and address sampled in the last cycle the strobe was active. The target register keeps its old value while the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe (style 0) or read/write level (style 1) |
| wr_n | input | 1 | Write strobe (style 0) or data strobe (style 1), active low |
| ale | input | 1 | Address-latch-enable for the multiplexed address mode |
| addr_pin | input | 5 | Word address when not multiplexed |
| data_in | input | 16 | Bus data in; bits 5..1 carry the address in multiplexed mode |
| data_out | output | 16 | Read data toward the bus |
| data_oe | output | 1 | Bus drive enable; high only while returning read data |
| strap_style | input | 1 | Strobe-style strap |
| strap_mux | input | 1 | Address-multiplex strap |
| mode_ctl | output | 16 | Mode-control word exported to the core |

## Verification
The bench targets aliasing between banks. It writes the same banked word in all three banks and reads each copy back, so a missing bank qualifier in the decode shows up as the last written value leaking into every bank. It writes the split and reserved addresses and then reads the neighbouring registers, so a decode that is too loose lets a reserved write overwrite a live word, and a missing read/write split returns mode_ctl instead of status. Two further cases cover the strobes and the address source. One holds a write strobe over several cycles with changing data, so a design that commits on the leading edge is caught with the old value still expected. The other runs the multiplexed mode with the address pins set to a deliberately wrong word, so a design that reads the pins lands the write somewhere else.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  // Strobe style selected by strap
  typedef enum logic {
    BUS_SEP_STROBES = 1'b0,
    BUS_RW_DS       = 1'b1
  } bus_style_e;

  // Word indices with fixed meaning (byte offset = 2 * index)
  localparam int WIDX_MODE      = 0;   // write: mode control, read: status
  localparam int WIDX_INTC      = 1;   // write: ignored, read: interrupt code (zero here)
  localparam int WIDX_COM_BASE  = 2;   // first common scratch word
  localparam int WIDX_BANK_BASE = 8;   // first banked word
  localparam int WIDX_BSEL      = 31;  // bank selector

  // Status word field positions
  localparam int ST_STYLE_BIT = 8;
  localparam int ST_MUX_BIT   = 9;
endpackage

// File: rtl/hreg_bus_front.sv
module hreg_bus_front
  import hreg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr_pin,
  input  logic [DATA_W-1:0] data_in,
  input  logic              strap_style,
  input  logic              strap_mux,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  logic              rd_act, wr_act;
  logic [ADDR_W-1:0] alat_q, alat_d, eff_addr;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              oe_q, wr_q;

  // Strobe decode for the two bus styles
  always_comb begin
    if (bus_style_e'(strap_style) == BUS_RW_DS) begin
      rd_act = !cs_n && !wr_n &&  rd_n;
      wr_act = !cs_n && !wr_n && !rd_n;
    end else begin
      rd_act = !cs_n && !rd_n;
      wr_act = !cs_n && !wr_n;
    end
  end

  // Address source: latch from data lines, or dedicated pins
  always_comb begin
    alat_d   = (strap_mux && ale) ? data_in[ADDR_W:1] : alat_q;
    eff_addr = strap_mux ? alat_q : addr_pin;
  end

  // Capture during active write; commit on release
  always_comb begin
    waddr_d = wr_act ? eff_addr : waddr_q;
    wdata_d = wr_act ? data_in  : wdata_q;
    dout_d  = rd_act ? rdata    : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alat_q  <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      dout_q  <= '0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      alat_q  <= alat_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      dout_q  <= dout_d;
      oe_q    <= rd_act;
      wr_q    <= wr_act;
    end
  end

  assign raddr    = eff_addr;
  assign wr_en    = wr_q && !wr_act;
  assign waddr    = waddr_q;
  assign wdata    = wdata_q;
  assign data_out = dout_q;
  assign data_oe  = oe_q;

  // R11: the bus is only driven after a cycle with chip select active
  a_r11_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(!cs_n));

  // R11: an idle bus carries zero
  a_r11_idle_out_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));

  // R12: a commit never lands while the write strobe is still active
  a_r12_commit_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(!cs_n && !wr_n && (bus_style_e'(strap_style) == BUS_SEP_STROBES || !rd_n)));
endmodule

// File: rtl/hreg_reg_file.sv
module hreg_reg_file
  import hreg_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 16,
  parameter int NUM_BANKS    = 3,
  parameter int COMMON_WORDS = 2,
  parameter int BANK_WORDS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              strap_style,
  input  logic              strap_mux,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mode_ctl
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [BANK_W-1:0] bank_q, bank_d;
  logic [DATA_W-1:0] mode_q, mode_d;
  logic [DATA_W-1:0] com_q [COMMON_WORDS];
  logic [DATA_W-1:0] com_d [COMMON_WORDS];
  logic [DATA_W-1:0] bnk_q [NUM_BANKS][BANK_WORDS];
  logic [DATA_W-1:0] bnk_d [NUM_BANKS][BANK_WORDS];
  logic [COMMON_WORDS-1:0] com_hit;
  logic [BANK_WORDS-1:0]   bnk_hit;
  logic              bsel_we, mode_we;
  logic [DATA_W-1:0] status;

  // Per-word write decodes
  for (genvar i = 0; i < COMMON_WORDS; i++) begin : g_com_dec
    assign com_hit[i] = wr_en && (waddr == ADDR_W'(WIDX_COM_BASE + i));
  end
  for (genvar j = 0; j < BANK_WORDS; j++) begin : g_bnk_dec
    assign bnk_hit[j] = wr_en && (waddr == ADDR_W'(WIDX_BANK_BASE + j));
  end

  assign mode_we = wr_en && (waddr == ADDR_W'(WIDX_MODE));
  assign bsel_we = wr_en && (waddr == ADDR_W'(WIDX_BSEL)) && (wdata < DATA_W'(NUM_BANKS));

  // Next state
  always_comb begin
    mode_d = mode_we ? wdata : mode_q;
    bank_d = bsel_we ? wdata[BANK_W-1:0] : bank_q;
    for (int i = 0; i < COMMON_WORDS; i++)
      com_d[i] = com_hit[i] ? wdata : com_q[i];
    for (int b = 0; b < NUM_BANKS; b++)
      for (int j = 0; j < BANK_WORDS; j++)
        bnk_d[b][j] = (bnk_hit[j] && bank_q == BANK_W'(b)) ? wdata : bnk_q[b][j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      bank_q <= '0;
      for (int i = 0; i < COMMON_WORDS; i++) com_q[i] <= '0;
      for (int b = 0; b < NUM_BANKS; b++)
        for (int j = 0; j < BANK_WORDS; j++) bnk_q[b][j] <= '0;
    end else begin
      mode_q <= mode_d;
      bank_q <= bank_d;
      com_q  <= com_d;
      bnk_q  <= bnk_d;
    end
  end

  // Status word on the read side of word 0
  always_comb begin
    status               = '0;
    status[BANK_W-1:0]   = bank_q;
    status[ST_STYLE_BIT] = strap_style;
    status[ST_MUX_BIT]   = strap_mux;
  end

  // Read side decode; unlisted words return zero
  always_comb begin
    rdata = '0;
    if (raddr == ADDR_W'(WIDX_MODE)) rdata = status;
    if (raddr == ADDR_W'(WIDX_BSEL)) rdata[BANK_W-1:0] = bank_q;
    for (int i = 0; i < COMMON_WORDS; i++)
      if (raddr == ADDR_W'(WIDX_COM_BASE + i)) rdata = com_q[i];
    for (int b = 0; b < NUM_BANKS; b++)
      for (int j = 0; j < BANK_WORDS; j++)
        if (raddr == ADDR_W'(WIDX_BANK_BASE + j) && bank_q == BANK_W'(b)) rdata = bnk_q[b][j];
  end

  assign mode_ctl = mode_q;

  // R2: selector never holds a bank that does not exist
  a_r2_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q < BANK_W'(NUM_BANKS));

  // R2: selector only moves on a committed write to its word
  a_r2_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && waddr == ADDR_W'(WIDX_BSEL)) |=> $stable(bank_q));

  // R12: mode control only changes on a commit
  a_r12_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_ctl));

  // R6: the interrupt-code word reads zero
  a_r6_intc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr == ADDR_W'(WIDX_INTC)) |-> (rdata == '0));
endmodule

// File: rtl/banked_host_regs.sv
module banked_host_regs #(
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 16,
  parameter int NUM_BANKS    = 3,
  parameter int COMMON_WORDS = 2,
  parameter int BANK_WORDS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr_pin,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic              strap_style,
  input  logic              strap_mux,
  output logic [DATA_W-1:0] mode_ctl
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] rdata, wdata;
  logic              wr_en;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  hreg_bus_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_front (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .ale        (ale),
    .addr_pin   (addr_pin),
    .data_in    (data_in),
    .strap_style(strap_style),
    .strap_mux  (strap_mux),
    .rdata      (rdata),
    .raddr      (raddr),
    .wr_en      (wr_en),
    .waddr      (waddr),
    .wdata      (wdata),
    .data_out   (data_out),
    .data_oe    (data_oe)
  );

  hreg_reg_file #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS),
    .COMMON_WORDS(COMMON_WORDS), .BANK_WORDS(BANK_WORDS)
  ) i_regs (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr_en      (wr_en),
    .waddr      (waddr),
    .wdata      (wdata),
    .raddr      (raddr),
    .strap_style(strap_style),
    .strap_mux  (strap_mux),
    .rdata      (rdata),
    .mode_ctl   (mode_ctl)
  );
endmodule

// File: tb/test_banked_host_regs.sv
`timescale 1ns/1ps
module test_banked_host_regs;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, rd_n, wr_n, ale, strap_style, strap_mux;
  logic [4:0]  addr_pin;
  logic [15:0] data_in;
  logic [15:0] data_out, mode_ctl;
  logic        data_oe;

  always #2 clk = ~clk;  // 250 MHz

  banked_host_regs i_banked_host_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ale(ale), .addr_pin(addr_pin), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe),
    .strap_style(strap_style), .strap_mux(strap_mux), .mode_ctl(mode_ctl)
  );

  int          checks = 0;
  int          failures = 0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ale = 1'b0;
  endtask

  // Present a word address in the current address mode
  task automatic put_addr(logic [4:0] a);
    if (strap_mux) begin
      addr_pin = ~a;               // wrong on purpose: pins must be ignored
      data_in  = {10'h0, a, 1'b0};
      ale = 1'b1;
      @(negedge clk);
      ale = 1'b0;
    end else begin
      addr_pin = a;
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    put_addr(a);
    data_in = d;
    cs_n = 1'b0;
    wr_n = 1'b0;
    rd_n = strap_style ? 1'b0 : 1'b1;
    @(negedge clk);
    go_idle();
    @(negedge clk);
  endtask

  // Driver: queue the expected word, then run the read cycle
  task automatic rd(logic [4:0] a, logic [15:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    put_addr(a);
    data_in = 16'h0;
    cs_n = 1'b0;
    if (strap_style) begin rd_n = 1'b1; wr_n = 1'b0; end
    else             begin rd_n = 1'b0; end
    @(negedge clk);
    go_idle();
    @(negedge clk);
  endtask

  // Monitor: pop and compare whenever the bus is driven
  always @(negedge clk) begin
    if (mon_on) begin
      if (data_oe) begin
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R11: unexpected drive, actual %h expected no drive", data_out);
        end else begin
          chk(tag_q.pop_front(), data_out, exp_q.pop_front());
        end
      end else if (data_out !== 16'h0) begin
        checks++; failures++;
        $display("FAIL R11: idle bus actual %h expected 0000", data_out);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; strap_style = 1'b0; strap_mux = 1'b0;
    addr_pin = 5'h0; data_in = 16'h0;
    go_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    chk("R1 mode_ctl", mode_ctl, 16'h0000);
    chk("R1 data_oe", {15'h0, data_oe}, 16'h0000);
    chk("R1 data_out", data_out, 16'h0000);
    rd(5'd31, 16'h0000, "R1 bank after reset");
    rd(5'd8,  16'h0000, "R1 banked word after reset");
    rd(5'd2,  16'h0000, "R1 common word after reset");

    // R8 separate strobes, R5 split word 00h
    wr(5'd0, 16'hA5C3);
    chk("R5 mode_ctl written", mode_ctl, 16'hA5C3);
    rd(5'd0, 16'h0000, "R5 status style0 mux0 bank0");
    // R6 word 02h
    wr(5'd1, 16'h1234);
    rd(5'd1, 16'h0000, "R6 intc read zero");
    chk("R6 write 02h no effect", mode_ctl, 16'hA5C3);
    // R3 common, R4 banked, R8 read/write strobes
    wr(5'd2, 16'h1111);
    wr(5'd3, 16'h2222);
    wr(5'd8, 16'hB000);
    wr(5'd11, 16'hB003);
    rd(5'd8, 16'hB000, "R8 read back bank0 10h");
    wr(5'd31, 16'h0001);
    rd(5'd31, 16'h0001, "R2 bank1 selected");
    wr(5'd8, 16'hB100);
    rd(5'd2, 16'h1111, "R3 common 04h in bank1");
    rd(5'd8, 16'hB100, "R4 bank1 10h");
    wr(5'd31, 16'h0002);
    wr(5'd8, 16'hB200);
    rd(5'd8, 16'hB200, "R4 bank2 10h");
    rd(5'd11, 16'h0000, "R4 bank2 16h untouched");
    rd(5'd3, 16'h2222, "R3 common 06h in bank2");
    wr(5'd31, 16'h0003);
    rd(5'd31, 16'h0002, "R2 value 3 ignored");
    wr(5'd31, 16'hFFFF);
    rd(5'd31, 16'h0002, "R2 value FFFF ignored");
    wr(5'd31, 16'h0000);
    rd(5'd8, 16'hB000, "R4 bank0 10h kept");
    rd(5'd11, 16'hB003, "R4 bank0 16h kept");
    wr(5'd31, 16'h0001);
    rd(5'd8, 16'hB100, "R4 bank1 10h kept");
    wr(5'd31, 16'h0000);

    // R7 reserved words
    wr(5'd4, 16'hDEAD);
    wr(5'd12, 16'hBEEF);
    wr(5'd30, 16'hCAFE);
    rd(5'd4,  16'h0000, "R7 08h reads zero");
    rd(5'd7,  16'h0000, "R7 0Eh reads zero");
    rd(5'd12, 16'h0000, "R7 18h reads zero");
    rd(5'd30, 16'h0000, "R7 3Ch reads zero");
    rd(5'd8,  16'hB000, "R7 banked word unchanged");
    rd(5'd2,  16'h1111, "R7 common word unchanged");
    chk("R7 mode_ctl unchanged", mode_ctl, 16'hA5C3);

    // R11 read strobe without chip select
    addr_pin = 5'd8; cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 no drive without cs", {15'h0, data_oe}, 16'h0000);
    go_idle();
    @(negedge clk);

    // R12 commit on release with last captured data
    addr_pin = 5'd0; data_in = 16'h1357; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    data_in = 16'h2468;
    @(negedge clk);
    chk("R12 old value while strobe held", mode_ctl, 16'hA5C3);
    go_idle();
    @(negedge clk);
    chk("R12 new value after release", mode_ctl, 16'h2468);

    // R9 read/write level with data strobe
    strap_style = 1'b1;
    @(negedge clk);
    rd(5'd0, 16'h0100, "R9 status style1");
    wr(5'd9, 16'h5A5A);
    rd(5'd9, 16'h5A5A, "R9 write and read back");
    wr(5'd0, 16'h0F0F);
    chk("R9 mode_ctl via data strobe", mode_ctl, 16'h0F0F);
    addr_pin = 5'd9; data_in = 16'hFFFF; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    go_idle();
    @(negedge clk);
    rd(5'd9, 16'h5A5A, "R9 no write with strobe high");

    // R10 multiplexed address
    strap_mux = 1'b1;
    @(negedge clk);
    wr(5'd31, 16'h0001);
    rd(5'd31, 16'h0001, "R10 bank select via latch");
    wr(5'd10, 16'h7777);
    rd(5'd10, 16'h7777, "R10 banked write via latch");
    rd(5'd0, 16'h0301, "R10 status style1 mux1 bank1");
    wr(5'd31, 16'h0000);
    rd(5'd10, 16'h0000, "R10 bank0 14h untouched");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R11: actual %0d reads unanswered expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule